// File: doc/BRIEF.md
# 64-Bit Request Qualifier

This block sits beside a PCI bus master. For each new or resumed transaction it decides whether the master may ask for the 64-bit data path. It then drives the active-low REQ64# pin so that the pin tracks FRAME#. The block reads the following inputs:

- the transaction kind;
- the two low address bits that matter for width (AD[3:2]);
- the number of Dwords in the posted-write buffer;
- a single-Dword flag and a prefetchable flag for reads;
- a direction flag that marks traffic headed upstream onto the primary bus;
- a strap sampled on every clock while reset is held;
- a flag marking a write that resumes after a target disconnect.

Any one of a fixed set of inhibit conditions removes the 64-bit request.

The decision comes from a small state machine with three states: ST_IDLE, ST_BURST and ST_FINISH. In ST_IDLE the enable follows the live verdict. When FRAME# first goes low in ST_IDLE (transition IDLE->BURST), the verdict is captured and held.

- ST_BURST moves to ST_FINISH when FRAME# returns high (BURST->FINISH).
- Either busy state returns to ST_IDLE on the end-of-transaction pulse (BURST->IDLE, FINISH->IDLE).

While the block is busy it watches ACK64# from the target. At the end pulse it records whether the target acknowledged 64-bit width, unless the attempt ended in a retry. That record governs the next resumed write.

Top module: `req64_qual`

## Requirements
- R1: REQ64# (`req64_n_o`) is low only while FRAME# (`frame_n_i`) is low and the enable is set. It falls in the same cycle FRAME# falls and rises in the same cycle FRAME# rises.
- R2: With `upstream_i`=1, no 64-bit request is made unless `strap_wide_i` was 1 while reset was held. Downstream traffic ignores the strap.
- R3: Kinds I/O (2), configuration (3), special cycle (4) and the unused codes 5 to 7 never request 64-bit width. Memory read is 0 and memory write is 1.
- R4: A start address with AD[2] (`addr_i[2]`) = 1 never requests 64-bit width.
- R5: A memory write with 3 or fewer Dwords in the posted buffer (`fill_dw_i`) never requests 64-bit width. With 4 or more it is eligible.
- R6: A memory read with `prefetch_i`=0 never requests 64-bit width.
- R7: A memory read with `single_dw_i`=1 never requests 64-bit width.
- R8: A prefetchable memory read with AD[3] (`addr_i[3]`) = 1 never requests 64-bit width.
- R9: A memory write with `resume_i`=1 gets no 64-bit request if the last recorded attempt saw no ACK64# low. Term codes are completion 0, disconnect 1, retry 2, abort 3. An attempt ending with retry leaves the record unchanged. The record reads "acknowledged" after reset.
- R10: The enable is frozen at the first cycle FRAME# is low. Input changes after that have no effect until the transaction ends.
- R11: A memory write or prefetchable read that meets none of the inhibit conditions requests 64-bit width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the strap is sampled while it is low |
| strap_wide_i | input | 1 | 1 = the central resource enabled 64-bit width during reset |
| upstream_i | input | 1 | 1 = transaction targets the primary bus |
| kind_i | input | 3 | Transaction kind: 0 memory read, 1 memory write, 2 I/O, 3 configuration, 4 special cycle |
| addr_i | input | 2 | Start address bits AD[3:2] |
| fill_dw_i | input | FILL_W | Dwords held in the posted-write buffer |
| single_dw_i | input | 1 | Read moves one Dword only |
| prefetch_i | input | 1 | Read targets prefetchable space |
| resume_i | input | 1 | Write resumes after a target disconnect |
| frame_n_i | input | 1 | FRAME# as driven by the master |
| ack64_n_i | input | 1 | ACK64# from the target |
| xfer_end_i | input | 1 | One-cycle pulse: current transaction has ended |
| term_i | input | 2 | Termination code, valid with `xfer_end_i` |
| wide_en_o | output | 1 | 64-bit request enable (live in idle, held while busy) |
| req64_n_o | output | 1 | REQ64# pin |

## Verification
Each transaction kind is driven with aligned and misaligned addresses, with the buffer fill on both sides of the four-Dword line, and with the single-Dword and prefetchable flags set in turn. This separates each inhibit rule from the others and from the eligible cases. Address and kind inputs are also flipped in the middle of a burst, in both directions, which shows whether the enable really stays frozen after the address phase. Runs of disconnected, retried and acknowledged writes, each followed by a resumed write, show whether the ACK64# record is updated or kept correctly. A second reset with the strap low separates upstream from downstream traffic.

// File: rtl/req64_pkg.sv
`timescale 1ns/1ps
package req64_pkg;
    localparam logic [2:0] KIND_MEM_RD  = 3'd0;
    localparam logic [2:0] KIND_MEM_WR  = 3'd1;
    localparam logic [2:0] KIND_IO      = 3'd2;
    localparam logic [2:0] KIND_CFG     = 3'd3;
    localparam logic [2:0] KIND_SPECIAL = 3'd4;

    typedef enum logic [1:0] {
        TERM_DONE  = 2'd0,
        TERM_DISC  = 2'd1,
        TERM_RETRY = 2'd2,
        TERM_ABORT = 2'd3
    } term_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BURST  = 2'd1,
        ST_FINISH = 2'd2
    } qual_state_e;
endpackage

// File: rtl/req64_strap.sv
`timescale 1ns/1ps
module req64_strap (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_i,
    output logic strap_q
);
    // Sampled on every edge while reset is held, then frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap_i;
    end
endmodule

// File: rtl/req64_rules.sv
`timescale 1ns/1ps
module req64_rules
    import req64_pkg::*;
#(
    parameter int FILL_W      = 6,
    parameter int WIDE_MIN_DW = 4
) (
    input  logic [2:0]        kind_i,
    input  logic [3:2]        addr_i,
    input  logic [FILL_W-1:0] fill_dw_i,
    input  logic              single_dw_i,
    input  logic              prefetch_i,
    input  logic              upstream_i,
    input  logic              strap_q,
    input  logic              resume_i,
    input  logic              hist_ok,
    output logic              allow_o
);
    localparam logic [FILL_W-1:0] MIN_FILL = FILL_W'(WIDE_MIN_DW);

    logic is_rd, is_wr, path_ok, rd_ok, wr_ok;

    always_comb begin
        is_rd   = (kind_i == KIND_MEM_RD);
        is_wr   = (kind_i == KIND_MEM_WR);
        path_ok = !(upstream_i && !strap_q) && !addr_i[2];
        rd_ok   = prefetch_i && !single_dw_i && !addr_i[3];
        wr_ok   = (fill_dw_i >= MIN_FILL) && !(resume_i && !hist_ok);
        allow_o = path_ok && ((is_rd && rd_ok) || (is_wr && wr_ok));
    end
endmodule

// File: rtl/req64_hist.sv
`timescale 1ns/1ps
module req64_hist
    import req64_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture_i,
    input  logic       busy_i,
    input  logic       ack64_n_i,
    input  logic       xfer_end_i,
    input  logic [1:0] term_i,
    output logic       hist_ok_o
);
    logic seen_q;
    logic ack_now;

    assign ack_now = seen_q | ~ack64_n_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q    <= 1'b0;
            hist_ok_o <= 1'b1;
        end else if (capture_i) begin
            seen_q <= 1'b0;
        end else if (busy_i) begin
            seen_q <= ack_now;
            if (xfer_end_i && term_i != TERM_RETRY) hist_ok_o <= ack_now;
        end
    end

    // R9: a retried attempt leaves the record untouched
    p_retry_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && xfer_end_i && term_i == TERM_RETRY) |=> $stable(hist_ok_o));
endmodule

// File: rtl/req64_fsm.sv
`timescale 1ns/1ps
module req64_fsm
    import req64_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n_i,
    input  logic xfer_end_i,
    input  logic verdict_i,
    output logic busy_o,
    output logic capture_o,
    output logic wide_en_o
);
    qual_state_e st_q, st_d;
    logic        held_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (!frame_n_i) st_d = ST_BURST;
            ST_BURST:  if (xfer_end_i) st_d = ST_IDLE;
                       else if (frame_n_i) st_d = ST_FINISH;
            ST_FINISH: if (xfer_end_i) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            held_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (capture_o) held_q <= verdict_i;
        end
    end

    always_comb begin
        unique case (st_q)
            ST_IDLE: begin
                busy_o    = 1'b0;
                capture_o = !frame_n_i;
                wide_en_o = verdict_i;
            end
            ST_BURST, ST_FINISH: begin
                busy_o    = 1'b1;
                capture_o = 1'b0;
                wide_en_o = held_q;
            end
            default: begin
                busy_o    = 1'b0;
                capture_o = 1'b0;
                wide_en_o = 1'b0;
            end
        endcase
    end

    // R10: the enable does not move once the transaction is under way
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || $stable(wide_en_o)));
endmodule

// File: rtl/req64_qual.sv
`timescale 1ns/1ps
module req64_qual
    import req64_pkg::*;
#(
    parameter int FILL_W      = 6,
    parameter int WIDE_MIN_DW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_wide_i,
    input  logic              upstream_i,
    input  logic [2:0]        kind_i,
    input  logic [3:2]        addr_i,
    input  logic [FILL_W-1:0] fill_dw_i,
    input  logic              single_dw_i,
    input  logic              prefetch_i,
    input  logic              resume_i,
    input  logic              frame_n_i,
    input  logic              ack64_n_i,
    input  logic              xfer_end_i,
    input  logic [1:0]        term_i,
    output logic              wide_en_o,
    output logic              req64_n_o
);
    logic strap_q, hist_ok, verdict, busy, capture;

    req64_strap u_strap (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_wide_i), .strap_q(strap_q)
    );

    req64_rules #(.FILL_W(FILL_W), .WIDE_MIN_DW(WIDE_MIN_DW)) u_rules (
        .kind_i(kind_i), .addr_i(addr_i), .fill_dw_i(fill_dw_i),
        .single_dw_i(single_dw_i), .prefetch_i(prefetch_i),
        .upstream_i(upstream_i), .strap_q(strap_q), .resume_i(resume_i),
        .hist_ok(hist_ok), .allow_o(verdict)
    );

    req64_hist u_hist (
        .clk(clk), .rst_n(rst_n), .capture_i(capture), .busy_i(busy),
        .ack64_n_i(ack64_n_i), .xfer_end_i(xfer_end_i), .term_i(term_i),
        .hist_ok_o(hist_ok)
    );

    req64_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_n_i(frame_n_i), .xfer_end_i(xfer_end_i),
        .verdict_i(verdict), .busy_o(busy), .capture_o(capture),
        .wide_en_o(wide_en_o)
    );

    assign req64_n_o = ~(wide_en_o & ~frame_n_i);

    localparam logic [FILL_W-1:0] LOW_FILL = FILL_W'(WIDE_MIN_DW - 1);

    // R1: pin never low outside FRAME#, and stays low through the burst
    p_pin_inside_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_n_i |-> req64_n_o);
    p_pin_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!req64_n_o && busy) |=> (frame_n_i || !req64_n_o));
    // R3: non-memory kinds are never widened
    p_kind_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && kind_i >= KIND_IO) |-> !wide_en_o);
    // R4: misaligned start
    p_misalign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && addr_i[2]) |-> !wide_en_o);
    // R5: shallow posted buffer
    p_shallow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && kind_i == KIND_MEM_WR && fill_dw_i <= LOW_FILL) |-> !wide_en_o);
    // R6: non-prefetchable read
    p_nonpref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && kind_i == KIND_MEM_RD && !prefetch_i) |-> !wide_en_o);
    // R9: resumed write after an unacknowledged attempt
    p_resume_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && kind_i == KIND_MEM_WR && resume_i && !hist_ok) |-> !wide_en_o);
endmodule

// File: tb/sim_req64_qual.sv
`timescale 1ns/1ps
module sim_req64_qual;
    localparam int FW = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n, strap_wide_i, upstream_i, single_dw_i, prefetch_i;
    logic          resume_i, frame_n_i, ack64_n_i, xfer_end_i;
    logic [2:0]    kind_i;
    logic [3:2]    addr_i;
    logic [FW-1:0] fill_dw_i;
    logic [1:0]    term_i;
    logic          wide_en_o, req64_n_o;

    req64_qual #(.FILL_W(FW), .WIDE_MIN_DW(4)) u0 (.*);

    int  n_checks = 0, n_fail = 0;
    bit  done = 0;
    bit  m_busy, m_held, m_ok, m_seen, m_strap;

    function automatic bit verdict(output string why);
        why = "R11";
        if (kind_i > 3'd1)                  begin why = "R3"; return 0; end
        if (upstream_i && !m_strap)         begin why = "R2"; return 0; end
        if (addr_i[2])                      begin why = "R4"; return 0; end
        if (kind_i == 3'd1) begin
            if (int'(fill_dw_i) < 4)        begin why = "R5"; return 0; end
            if (resume_i && !m_ok)          begin why = "R9"; return 0; end
            return 1;
        end
        if (!prefetch_i)                    begin why = "R6"; return 0; end
        if (single_dw_i)                    begin why = "R7"; return 0; end
        if (addr_i[3])                      begin why = "R8"; return 0; end
        return 1;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input bit act, input bit exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cyc();
        string why;
        bit e_en, e_req, v;
        #2;
        if (rst_n) begin
            if (m_busy) begin e_en = m_held; why = "R10"; end
            else e_en = verdict(why);
            e_req = !(e_en && !frame_n_i);
            check(wide_en_o == e_en, why, "wide_en_o", wide_en_o, e_en);
            check(req64_n_o == e_req, "R1", "req64_n_o", req64_n_o, e_req);
        end
        @(posedge clk);
        if (!rst_n) begin
            m_busy = 0; m_ok = 1; m_seen = 0; m_strap = strap_wide_i;
        end else if (!m_busy) begin
            if (!frame_n_i) begin m_held = verdict(why); m_busy = 1; m_seen = 0; end
        end else if (xfer_end_i) begin
            if (term_i != 2'd2) m_ok = m_seen || !ack64_n_i;
            m_busy = 0;
        end else if (!ack64_n_i) m_seen = 1;
        v = 0;
        @(negedge clk);
    endtask

    task automatic do_reset(input bit strap);
        rst_n = 0; strap_wide_i = strap;
        repeat (3) cyc();
        rst_n = 1;
        cyc();
    endtask

    task automatic txn(input logic [2:0] kind, input logic [3:2] a,
                       input int fill, input bit single, input bit pref,
                       input bit up, input bit resume, input bit ack,
                       input logic [1:0] term, input int len, input bit perturb);
        kind_i = kind; addr_i = a; fill_dw_i = FW'(fill); single_dw_i = single;
        prefetch_i = pref; upstream_i = up; resume_i = resume;
        cyc();                     // idle preview of the verdict
        frame_n_i = 0;
        cyc();                     // address phase
        ack64_n_i = !ack;
        for (int i = 0; i < len; i++) begin
            if (perturb) begin
                addr_i = ~addr_i; kind_i = (i % 2 == 0) ? 3'd2 : 3'd1;
                fill_dw_i = FW'(i); prefetch_i = ~prefetch_i;
            end
            cyc();
        end
        frame_n_i = 1;
        cyc();
        xfer_end_i = 1; term_i = term;
        cyc();
        xfer_end_i = 0; ack64_n_i = 1; term_i = 2'd0;
        cyc();
    endtask

    initial begin
        rst_n = 0; strap_wide_i = 1; upstream_i = 0; kind_i = 0; addr_i = 0;
        fill_dw_i = 0; single_dw_i = 0; prefetch_i = 0; resume_i = 0;
        frame_n_i = 1; ack64_n_i = 1; xfer_end_i = 0; term_i = 0;
        m_busy = 0; m_held = 0; m_ok = 1; m_seen = 0; m_strap = 1;
        @(negedge clk);
        do_reset(1'b1);
        // reset state: idle, pin released
        check(req64_n_o == 1'b1, "R1", "reset pin", req64_n_o, 1'b1);
        // R11 / R5: write eligibility around the fill threshold
        txn(3'd1, 2'b00, 8, 0, 0, 0, 0, 1, 2'd0, 3, 0);
        txn(3'd1, 2'b00, 3, 0, 0, 0, 0, 0, 2'd0, 2, 0);
        txn(3'd1, 2'b00, 4, 0, 0, 0, 0, 1, 2'd0, 2, 0);
        txn(3'd1, 2'b00, 0, 0, 0, 0, 0, 0, 2'd0, 1, 0);
        // R3: every non-memory code
        for (int k = 2; k < 8; k++) txn(3'(k), 2'b00, 8, 0, 1, 0, 0, 0, 2'd0, 1, 0);
        // R6, R7, R8, R11 reads; R4 misaligned reads and writes
        txn(3'd0, 2'b00, 0, 0, 0, 0, 0, 0, 2'd0, 2, 0);
        txn(3'd0, 2'b00, 0, 1, 1, 0, 0, 0, 2'd0, 1, 0);
        txn(3'd0, 2'b10, 0, 0, 1, 0, 0, 0, 2'd0, 2, 0);
        txn(3'd0, 2'b00, 0, 0, 1, 0, 0, 1, 2'd0, 4, 0);
        txn(3'd0, 2'b01, 0, 0, 1, 0, 0, 0, 2'd0, 2, 0);
        txn(3'd1, 2'b01, 16, 0, 0, 0, 0, 0, 2'd0, 2, 0);
        txn(3'd1, 2'b10, 16, 0, 0, 0, 0, 1, 2'd0, 2, 0);
        // R10: inputs flipped mid-burst in both directions
        txn(3'd1, 2'b00, 12, 0, 0, 0, 0, 1, 2'd0, 5, 1);
        txn(3'd0, 2'b01, 0, 0, 0, 0, 0, 0, 2'd0, 5, 1);
        // R9: disconnect without ACK64#, then resumes
        txn(3'd1, 2'b00, 8, 0, 0, 0, 0, 0, 2'd1, 2, 0);
        txn(3'd1, 2'b00, 8, 0, 0, 0, 1, 0, 2'd2, 2, 0);   // resumed: blocked, retry keeps record
        txn(3'd1, 2'b00, 8, 0, 0, 0, 1, 0, 2'd1, 2, 0);   // still blocked
        txn(3'd0, 2'b00, 0, 0, 1, 0, 1, 1, 2'd0, 2, 0);   // read ignores resume; ack recorded
        txn(3'd1, 2'b00, 8, 0, 0, 0, 1, 1, 2'd1, 2, 0);   // now allowed
        txn(3'd1, 2'b00, 8, 0, 0, 0, 1, 0, 2'd2, 2, 0);   // retry w/o ack keeps ok
        txn(3'd1, 2'b00, 8, 0, 0, 0, 1, 0, 2'd3, 2, 0);   // allowed; abort clears
        txn(3'd1, 2'b00, 8, 0, 0, 0, 1, 0, 2'd0, 2, 0);   // blocked
        // R2: upstream with strap high, then re-reset with strap low
        txn(3'd1, 2'b00, 8, 0, 0, 1, 0, 1, 2'd0, 2, 0);
        do_reset(1'b0);
        txn(3'd1, 2'b00, 8, 0, 0, 0, 1, 0, 2'd0, 2, 0);   // R9 record restored by reset
        txn(3'd1, 2'b00, 8, 0, 0, 1, 0, 0, 2'd0, 2, 0);
        txn(3'd0, 2'b00, 0, 0, 1, 1, 0, 0, 2'd0, 2, 0);
        txn(3'd0, 2'b00, 0, 0, 1, 0, 0, 1, 2'd0, 2, 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule